// File: doc/BRIEF.md
# Guarded Synchronous ROM

This block is a read-only lookup memory whose contents are fixed when the device is configured, wrapped by a small controller. On-chip RAM arrays used this way can lose their contents if the address moves inside the setup window while the port is enabled. This can happen when the clock glitches, even if no write is ever requested. The controller therefore keeps the array port disabled until the clock source reports lock. The lock indication must then stay high for a programmable number of edges before reads are allowed.

A system that intends to change clock sources raises a switch request. The controller turns the port off at the next edge and answers with an acknowledge once the port is off, so the clock can then be changed safely. If lock disappears while the port is on and no switch was announced, the contents can no longer be trusted. A sticky flag then tells the surrounding system that the memory must be reloaded or the device reconfigured. Only reset clears that flag.

Reads are registered twice. An accepted request captures the address. On the next edge the array is enabled with an address that has been stable for a full cycle, and the returned word is presented together with a one-cycle valid strobe.

Top module: `guarded_rom`

## Requirements
- R1: The word returned for address a equals the low DATA_W bits of (a * 40503) XOR 23130 (with defaults, 16 bits and 64 words); no write path exists.
- R2: A request that is accepted at clock edge k produces rd_data and a rd_valid pulse one cycle wide, both visible after edge k+1. Back-to-back accepted requests produce back-to-back pulses.
- R3: From reset, all outputs are zero and the port stays disabled until lock has been observed.
- R4: The port enables only at the edge that completes SETTLE_CYCLES consecutive edges sampling lock high with no switch request; a low lock or a switch request restarts the count.
- R5: rd_req while the port is disabled is ignored: no rd_valid follows and rd_data keeps its previous value.
- R6: A switch request sampled while enabled disables the port at that edge; switch_ack is high from the following edge for as long as the request stays high with the port off, and drops one edge after release.
- R7: After the switch request is released, re-enabling takes a full new settle interval.
- R8: Lock sampled low while the port is enabled sets contents_suspect at that edge, also when a switch request arrives in the same cycle; it stays set until reset.
- R9: Lock going low while the port is already disabled leaves contents_suspect unchanged.
- R10: The address feeding the array changes only on accepted requests, and the array is enabled only while the controller's enable is on.
- R11: A request is accepted only when the port is enabled, lock is high and no switch request is present in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_locked | input | 1 | Clock source reports lock |
| switch_req | input | 1 | Announced clock change request |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Word read from the array |
| rd_valid | output | 1 | One-cycle strobe marking new rd_data |
| switch_ack | output | 1 | Port is off, the clock may be switched |
| contents_suspect | output | 1 | Sticky flag: lock lost while enabled |

## Verification
Two events can coincide in one cycle: loss of lock, and an announced switch request or a read request. A directed case drops lock on the same edge that a switch request appears while the port is on. The expected result is that the suspect flag is set and no read is accepted. A second directed case drops lock in the middle of an acknowledged switch, where the flag must stay clear. Random phases then overlap lock drops, switch windows and continuous reads with changing addresses. A cycle model built from the requirements judges rd_valid, rd_data, switch_ack and the flag at every negative edge.

// File: rtl/grom_pkg.sv
package grom_pkg;
   localparam logic [63:0] ROM_MULT = 64'd40503;
   localparam logic [63:0] ROM_XOR  = 64'd23130;

   // Content generator for the fixed array (R1)
   function automatic logic [63:0] rom_word(input logic [63:0] a);
      return (a * ROM_MULT) ^ ROM_XOR;
   endfunction
endpackage

// File: rtl/grom_guard.sv
module grom_guard #(
   parameter int SETTLE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock,
   input  logic sw_req,
   output logic port_en,
   output logic accept_ok,
   output logic sw_ack,
   output logic suspect
);
   localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SETTLE_CYCLES);

   generate
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("grom_guard: SETTLE_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] settle_q;

   // a read may start only if the enable survives this edge (R11)
   assign accept_ok = port_en & lock & ~sw_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_en  <= 1'b0;
         settle_q <= '0;
         sw_ack   <= 1'b0;
         suspect  <= 1'b0;
      end else begin
         sw_ack <= sw_req & ~port_en;
         if (port_en) begin
            settle_q <= '0;
            if (!lock) begin
               port_en <= 1'b0;
               suspect <= 1'b1;
            end else if (sw_req) begin
               port_en <= 1'b0;
            end
         end else if (lock && !sw_req) begin
            if (settle_q == CNT_LAST) begin
               port_en  <= 1'b1;
               settle_q <= '0;
            end else begin
               settle_q <= settle_q + 1'b1;
            end
         end else begin
            settle_q <= '0;
         end
      end
   end

   // independent run-length of locked edges, used only by the settle check
   logic [CNT_W-1:0] lock_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               lock_run_q <= '0;
      else if (!lock)           lock_run_q <= '0;
      else if (lock_run_q != CNT_FULL) lock_run_q <= lock_run_q + 1'b1;
   end

   p_settle_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_en) |-> lock_run_q == CNT_FULL);
   p_en_after_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      port_en |-> $past(lock));
   p_ack_port_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sw_ack |-> !port_en);
   p_suspect_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(suspect) |-> suspect);
   p_suspect_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspect) |-> ($past(port_en) && !$past(lock)));
endmodule

// File: rtl/grom_array.sv
module grom_array #(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] dout
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (USE_TABLE) begin : g_table
         logic [DATA_W-1:0] mem [DEPTH];
         initial begin
            for (int i = 0; i < DEPTH; i++)
               mem[i] = DATA_W'(grom_pkg::rom_word(64'(i)));
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  dout <= '0;
            else if (ce) dout <= mem[addr];
         end
      end else begin : g_logic
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  dout <= '0;
            else if (ce) dout <= DATA_W'(grom_pkg::rom_word(64'(addr)));
         end
      end
   endgenerate
endmodule

// File: rtl/guarded_rom.sv
module guarded_rom #(
   parameter int ADDR_W        = 6,
   parameter int DATA_W        = 16,
   parameter int SETTLE_CYCLES = 16,
   parameter bit USE_TABLE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_locked,
   input  logic              switch_req,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              switch_ack,
   output logic              contents_suspect
);
   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("guarded_rom: ADDR_W out of range 1..12");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
         $error("guarded_rom: DATA_W out of range 1..64");
      end
   endgenerate

   logic              port_en, accept_ok, accept;
   logic              fire_q;
   logic [ADDR_W-1:0] addr_q;

   grom_guard #(.SETTLE_CYCLES(SETTLE_CYCLES)) guard_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock     (clk_locked),
      .sw_req   (switch_req),
      .port_en  (port_en),
      .accept_ok(accept_ok),
      .sw_ack   (switch_ack),
      .suspect  (contents_suspect)
   );

   assign accept = accept_ok & rd_req;

   // address stage: loaded only with an accepted read (R10)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         fire_q   <= 1'b0;
         rd_valid <= 1'b0;
      end else begin
         fire_q   <= accept;
         rd_valid <= fire_q;
         if (accept) addr_q <= rd_addr;
      end
   end

   grom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .USE_TABLE(USE_TABLE)) array_i (
      .clk  (clk),
      .rst_n(rst_n),
      .ce   (fire_q),
      .addr (addr_q),
      .dout (rd_data)
   );

   p_array_guarded_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fire_q |-> port_en);
   p_valid_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req, 2));
   p_data_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> $stable(rd_data));
   p_accept_needs_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fire_q |-> ($past(clk_locked) && !$past(switch_req)));
endmodule

// File: tb/guarded_rom_tb_top.sv
`timescale 1ns/1ps
module guarded_rom_tb_top;
   localparam int AW = 6;
   localparam int DW = 16;
   localparam int ST = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clk_locked = 1'b0, switch_req = 1'b0, rd_req = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic rd_valid, switch_ack, contents_suspect;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   guarded_rom #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYCLES(ST)) dut_i (
      .clk(clk), .rst_n(rst_n), .clk_locked(clk_locked), .switch_req(switch_req),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
      .switch_ack(switch_ack), .contents_suspect(contents_suspect));

   // expected word from R1
   function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
      logic [31:0] p;
      p = 32'(a) * 32'd40503;
      return p[15:0] ^ 16'd23130;
   endfunction

   // requirement-level cycle model
   bit m_en, m_ack, m_susp, m_fire, m_valid;
   int m_cnt;
   logic [AW-1:0] m_aq;
   logic [DW-1:0] m_dout;

   task automatic model_reset();
      m_en = 0; m_ack = 0; m_susp = 0; m_fire = 0; m_valid = 0;
      m_cnt = 0; m_aq = '0; m_dout = '0;
   endtask

   task automatic model_next(input bit lk, input bit sw, input bit rd, input logic [AW-1:0] ad);
      bit acc;
      acc = m_en && lk && !sw && rd;          // R11
      m_valid = m_fire;                      // R2
      if (m_fire) m_dout = exp_word(m_aq);   // R1
      m_fire = acc;
      if (acc) m_aq = ad;                    // R10
      m_ack = sw && !m_en;                   // R6
      if (m_en) begin
         m_cnt = 0;
         if (!lk) begin m_en = 0; m_susp = 1; end  // R8
         else if (sw) m_en = 0;
      end else if (lk && !sw) begin           // R4, R7; R9: no flag here
         if (m_cnt == ST - 1) begin m_en = 1; m_cnt = 0; end
         else m_cnt++;
      end else m_cnt = 0;
   endtask

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_outputs();
      chk(rd_valid === m_valid, "R2/R5 rd_valid", rd_valid, m_valid);
      chk(rd_data === m_dout, "R1/R2 rd_data", rd_data, m_dout);
      chk(switch_ack === m_ack, "R6 switch_ack", switch_ack, m_ack);
      chk(contents_suspect === m_susp, "R8/R9 contents_suspect", contents_suspect, m_susp);
   endtask

   task automatic step(input bit lk, input bit sw, input bit rd, input logic [AW-1:0] ad);
      check_outputs();
      clk_locked = lk; switch_req = sw; rd_req = rd; rd_addr = ad;
      model_next(lk, sw, rd, ad);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      // R3: reset state
      chk(rd_valid === 1'b0 && switch_ack === 1'b0 && contents_suspect === 1'b0,
          "R3 reset outputs", {rd_valid, switch_ack, contents_suspect}, 0);
      chk(rd_data === '0, "R3 reset data", rd_data, 0);
      rst_n = 1'b1;
   endtask

   function automatic logic [AW-1:0] raddr();
      return AW'($urandom);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();

      // R3/R5: reads without lock are ignored
      for (int i = 0; i < 8; i++) step(0, 0, 1, raddr());
      // R4: lock drop at count 10 restarts the settle interval
      for (int i = 0; i < 10; i++) step(1, 0, 1, raddr());
      step(0, 0, 1, raddr());
      for (int i = 0; i < ST + 6; i++) step(1, 0, 1, AW'(i));
      // R1: sweep every address back to back
      for (int i = 0; i < (1 << AW); i++) step(1, 0, 1, AW'(i));
      // R6: announced switch, then R9: lock lost while port is off
      for (int i = 0; i < 4; i++) step(1, 1, 1, raddr());
      for (int i = 0; i < 5; i++) step(0, 1, 1, raddr());
      for (int i = 0; i < 3; i++) step(1, 1, 0, raddr());
      // R7: release, full settle again
      for (int i = 0; i < ST + 4; i++) step(1, 0, 1, raddr());
      // R8 + R11: lock loss and switch request in the same cycle
      step(0, 1, 1, raddr());
      for (int i = 0; i < 4; i++) step(1, 0, 1, raddr());
      do_reset();
      // R8: unannounced lock loss during reads, flag sticky
      for (int i = 0; i < ST + 3; i++) step(1, 0, 1, raddr());
      step(0, 0, 1, raddr());
      for (int i = 0; i < ST + 5; i++) step(1, 0, (i % 3) != 0, raddr());
      step(1, 0, 0, raddr());

      // random phases
      begin
         int lock_off = 0, sw_left = 0;
         for (int i = 0; i < 6000; i++) begin
            bit lk, sw, rd;
            if (i % 1500 == 0) do_reset();
            if (lock_off > 0) lock_off--;
            else if ($urandom_range(0, 199) == 0) lock_off = $urandom_range(1, 6);
            if (sw_left > 0) sw_left--;
            else if ($urandom_range(0, 149) == 0) sw_left = $urandom_range(2, 30);
            lk = (lock_off == 0);
            sw = (sw_left > 0);
            rd = ($urandom_range(0, 3) != 0);
            step(lk, sw, rd, raddr());
         end
      end
      check_outputs();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule